// File: doc/BRIEF.md
# Task-File Command Issue Engine

This block issues one command to a disk controller that uses a task-file register set. The registers sit behind an 8-bit bus with a 3-bit register address. On a start pulse the engine captures the command byte, six parameter bytes, the target head number, the base control-register value and a flag that marks the command as a media command (read, write, seek or recalibrate). It then walks the task file in a fixed order. Before every single register write it polls the status register until the device reports that it is no longer busy.

Once the command byte is in, the engine waits for the device's completion interrupt under a timeout. It then reads status once and reduces the outcome to a 3-bit result code. Interrupt pulses left over from earlier activity are discarded when a command starts. An interrupt that turns up while the registers are still being written is remembered, so that a later timeout can be reported as a missed interrupt rather than a plain timeout. Poll spacing, poll count and interrupt timeout are all given in clock cycles.

Top module: `tfc_cmd_engine`

## Requirements
- R1: While reset is held and after it is released, wr_en, rd_en, ctrl_wr, active and done are all low, and err_code reads 0.
- R2: The engine writes the parameter registers in ascending address order 1 to 6, each with its own byte (byte k is param_bytes[8k-1:8k-8]). It then writes cmd_byte to address 7, and address 7 is always the last write.
- R3: Each task-file write is preceded by a status read (rd_en with addr 7, data returned on rdata the following cycle) that returned bit 7 (BUSY) clear. A busy reply is retried after POLL_GAP idle cycles.
- R4: If POLL_TRIES consecutive status reads before one write all report BUSY, the engine ends with err_code 1 (not ready) and makes no further writes.
- R5: When head_num is greater than 7, the engine writes ctrl_base with bit 3 set, once, through ctrl_wr, before any task-file write. When head_num is 7 or less, ctrl_wr never pulses.
- R6: An interrupt pulse received while the engine is idle has no effect on the next command. It neither ends the wait early nor turns a timeout into a missed interrupt.
- R7: If no interrupt arrives within WAIT_CYCLES cycles after the command write, done rises exactly WAIT_CYCLES+1 cycles after that write. err_code is then 3 (missed interrupt) if an interrupt was seen while the registers were being written, and 2 (timeout) otherwise.
- R8: An interrupt during the wait is followed by one status read. If status bit 0 (ERROR) is set, the result is 4, whatever the other bits hold.
- R9: With ERROR clear, status bit 5 (write fault) gives result 5 when media_cmd was set, and result 0 when it was clear. A clean status gives 0.
- R10: done is a one-cycle pulse, active is high from the cycle after start until done, and err_code keeps its value while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a command (taken only when idle) |
| cmd_byte | input | 8 | Command code, written last to address 7 |
| param_bytes | input | 48 | Six parameter bytes, byte k for address k |
| head_num | input | 4 | Target head number |
| ctrl_base | input | 8 | Stored control-register value |
| media_cmd | input | 1 | Command is read, write, seek or recalibrate |
| irq | input | 1 | Device completion interrupt |
| rdata | input | 8 | Register read data, valid one cycle after rd_en |
| addr | output | 3 | Task-file register address |
| wdata | output | 8 | Register write data |
| wr_en | output | 1 | Task-file register write strobe |
| rd_en | output | 1 | Register read strobe |
| ctrl_wr | output | 1 | Control-register write strobe |
| active | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result: 0 ok, 1 not ready, 2 timeout, 3 missed interrupt, 4 device error, 5 write fault |

## Verification
The issue sequence is run with a device that is never busy, one that stays busy for two polls before every write, one that is busy forever from the start, and one that locks up after the second write. Together these separate correct ordering, per-write polling and both abort points. Low and high head numbers separate the presence and absence of the control write. Interrupt timing is varied four ways: a normal delayed completion, no completion at all, a stray pulse during the write phase, and a stale pulse while idle. Because the exact done cycle is checked, an early exit from the wait shows up. Status patterns with ERROR, write fault, both bits, and write fault on a non-media command separate the classification priorities.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

   typedef enum logic [2:0] {
      ERR_NONE        = 3'd0,
      ERR_NOT_READY   = 3'd1,
      ERR_TIMEOUT     = 3'd2,
      ERR_MISSED_IRQ  = 3'd3,
      ERR_DEVICE      = 3'd4,
      ERR_WRITE_FAULT = 3'd5
   } tfc_err_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_HIGH,
      S_PRD,
      S_PCHK,
      S_PGAP,
      S_WR,
      S_WAIT,
      S_SRD,
      S_SCHK,
      S_DONE
   } tfc_state_e;

endpackage

// File: rtl/tfc_countdown.sv
module tfc_countdown #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/tfc_irq_catch.sv
module tfc_irq_catch #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq,
   input  logic flush,
   input  logic snap,
   output logic pend,
   output logic early
);

   logic irq_s;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign irq_s = irq;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q <= {sync_q[SYNC_STAGES-2:0], irq};
            end
         end
         assign irq_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   logic pend_q, early_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         early_q <= 1'b0;
      end else if (flush) begin
         pend_q  <= 1'b0;
         early_q <= 1'b0;
      end else if (snap) begin
         early_q <= pend_q | irq_s;
         pend_q  <= 1'b0;
      end else begin
         pend_q  <= pend_q | irq_s;
      end
   end

   assign pend  = pend_q;
   assign early = early_q;

endmodule

// File: rtl/tfc_stat_class.sv
module tfc_stat_class #(
   parameter int DATA_W   = 8,
   parameter int ERR_BIT  = 0,
   parameter int WFLT_BIT = 5
) (
   input  logic [DATA_W-1:0] stat,
   input  logic              media,
   output tfc_pkg::tfc_err_e code
);

   always_comb begin
      if (stat[ERR_BIT]) begin
         code = tfc_pkg::ERR_DEVICE;
      end else if (media && stat[WFLT_BIT]) begin
         code = tfc_pkg::ERR_WRITE_FAULT;
      end else begin
         code = tfc_pkg::ERR_NONE;
      end
   end

endmodule

// File: rtl/tfc_cmd_engine.sv
module tfc_cmd_engine #(
   parameter int DATA_W      = 8,
   parameter int REG_AW      = 3,
   parameter int HEAD_W      = 4,
   parameter int HEAD_LIMIT  = 7,
   parameter int BUSY_BIT    = 7,
   parameter int ERR_BIT     = 0,
   parameter int WFLT_BIT    = 5,
   parameter int HH_BIT      = 3,
   parameter int POLL_GAP    = 8,
   parameter int POLL_TRIES  = 60,
   parameter int WAIT_CYCLES = 400,
   parameter int IRQ_SYNC    = 0,
   localparam int CMD_REG    = (1 << REG_AW) - 1,
   localparam int NPARAM     = CMD_REG - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [DATA_W-1:0]        cmd_byte,
   input  logic [NPARAM*DATA_W-1:0] param_bytes,
   input  logic [HEAD_W-1:0]        head_num,
   input  logic [DATA_W-1:0]        ctrl_base,
   input  logic                     media_cmd,
   input  logic                     irq,
   input  logic [DATA_W-1:0]        rdata,
   output logic [REG_AW-1:0]        addr,
   output logic [DATA_W-1:0]        wdata,
   output logic                     wr_en,
   output logic                     rd_en,
   output logic                     ctrl_wr,
   output logic                     active,
   output logic                     done,
   output logic [2:0]               err_code
);

   import tfc_pkg::*;

   localparam int TRY_W  = $clog2(POLL_TRIES + 1);
   localparam int GAP_W  = $clog2(POLL_GAP + 1);
   localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);
   localparam logic [TRY_W-1:0]  LAST_TRY = TRY_W'(POLL_TRIES - 1);
   localparam logic [GAP_W-1:0]  GAP_LOAD = GAP_W'(POLL_GAP - 1);
   localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(WAIT_CYCLES - 1);
   localparam logic [REG_AW-1:0] CMD_ADDR = REG_AW'(CMD_REG);

   // elaboration-time parameter checks
   if (DATA_W < 8) begin : g_bad_dw
      $error("DATA_W must be at least 8");
   end
   if (REG_AW < 2) begin : g_bad_aw
      $error("REG_AW must be at least 2");
   end
   if (BUSY_BIT >= DATA_W || ERR_BIT >= DATA_W || WFLT_BIT >= DATA_W || HH_BIT >= DATA_W) begin : g_bad_bits
      $error("status or control bit position outside DATA_W");
   end
   if (POLL_TRIES < 1 || POLL_GAP < 1 || WAIT_CYCLES < 1) begin : g_bad_counts
      $error("POLL_TRIES, POLL_GAP and WAIT_CYCLES must be at least 1");
   end
   if (HEAD_LIMIT < 0 || HEAD_LIMIT >= (1 << HEAD_W)) begin : g_bad_head
      $error("HEAD_LIMIT outside head_num range");
   end
   if (IRQ_SYNC == 1) begin : g_bad_sync
      $error("IRQ_SYNC must be 0 or at least 2");
   end

   tfc_state_e             state_q, state_d;
   logic [REG_AW-1:0]      idx_q, idx_d;
   logic [TRY_W-1:0]       tries_q, tries_d;
   tfc_err_e               err_q, err_d;
   logic [DATA_W-1:0]      cmd_q;
   logic [NPARAM*DATA_W-1:0] par_q;
   logic [DATA_W-1:0]      ctrl_q;
   logic                   media_q;

   logic gap_load, gap_dec, gap_zero;
   logic tmo_load, tmo_dec, tmo_zero;
   logic flush, snap, pend, early;
   tfc_err_e class_code;

   // register image by address: 0 unused, 1..NPARAM parameters, CMD_REG command
   logic [DATA_W-1:0] reg_img [0:CMD_REG];

   generate
      for (genvar k = 0; k <= CMD_REG; k++) begin : g_img
         if (k == 0) begin : g_zero
            assign reg_img[k] = '0;
         end else if (k == CMD_REG) begin : g_cmd
            assign reg_img[k] = cmd_q;
         end else begin : g_par
            assign reg_img[k] = par_q[(k-1)*DATA_W +: DATA_W];
         end
      end
   endgenerate

   tfc_countdown #(.CNT_W(GAP_W)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (gap_load),
      .load_val (GAP_LOAD),
      .dec      (gap_dec),
      .zero     (gap_zero)
   );

   tfc_countdown #(.CNT_W(WAIT_W)) u_tmo (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmo_load),
      .load_val (WAIT_LOAD),
      .dec      (tmo_dec),
      .zero     (tmo_zero)
   );

   tfc_irq_catch #(.SYNC_STAGES(IRQ_SYNC)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .irq   (irq),
      .flush (flush),
      .snap  (snap),
      .pend  (pend),
      .early (early)
   );

   tfc_stat_class #(
      .DATA_W   (DATA_W),
      .ERR_BIT  (ERR_BIT),
      .WFLT_BIT (WFLT_BIT)
   ) u_class (
      .stat  (rdata),
      .media (media_q),
      .code  (class_code)
   );

   always_comb begin
      state_d  = state_q;
      idx_d    = idx_q;
      tries_d  = tries_q;
      err_d    = err_q;
      gap_load = 1'b0;
      gap_dec  = 1'b0;
      tmo_load = 1'b0;
      tmo_dec  = 1'b0;
      flush    = 1'b0;
      snap     = 1'b0;
      case (state_q)
         S_IDLE: begin
            if (start) begin
               flush   = 1'b1;
               idx_d   = REG_AW'(1);
               tries_d = '0;
               state_d = (int'(head_num) > HEAD_LIMIT) ? S_HIGH : S_PRD;
            end
         end
         S_HIGH: state_d = S_PRD;
         S_PRD:  state_d = S_PCHK;
         S_PCHK: begin
            if (!rdata[BUSY_BIT]) begin
               state_d = S_WR;
            end else if (tries_q == LAST_TRY) begin
               err_d   = ERR_NOT_READY;
               state_d = S_DONE;
            end else begin
               tries_d  = tries_q + 1'b1;
               gap_load = 1'b1;
               state_d  = S_PGAP;
            end
         end
         S_PGAP: begin
            if (gap_zero) begin
               state_d = S_PRD;
            end else begin
               gap_dec = 1'b1;
            end
         end
         S_WR: begin
            tries_d = '0;
            if (idx_q == CMD_ADDR) begin
               snap     = 1'b1;
               tmo_load = 1'b1;
               state_d  = S_WAIT;
            end else begin
               idx_d   = idx_q + 1'b1;
               state_d = S_PRD;
            end
         end
         S_WAIT: begin
            if (pend) begin
               state_d = S_SRD;
            end else if (tmo_zero) begin
               err_d   = early ? ERR_MISSED_IRQ : ERR_TIMEOUT;
               state_d = S_DONE;
            end else begin
               tmo_dec = 1'b1;
            end
         end
         S_SRD:  state_d = S_SCHK;
         S_SCHK: begin
            err_d   = class_code;
            state_d = S_DONE;
         end
         S_DONE:  state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         tries_q <= '0;
         err_q   <= ERR_NONE;
         cmd_q   <= '0;
         par_q   <= '0;
         ctrl_q  <= '0;
         media_q <= 1'b0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         tries_q <= tries_d;
         err_q   <= err_d;
         if (state_q == S_IDLE && start) begin
            cmd_q   <= cmd_byte;
            par_q   <= param_bytes;
            ctrl_q  <= ctrl_base;
            media_q <= media_cmd;
         end
      end
   end

   always_comb begin
      addr    = '0;
      wdata   = '0;
      wr_en   = 1'b0;
      rd_en   = 1'b0;
      ctrl_wr = 1'b0;
      case (state_q)
         S_HIGH: begin
            ctrl_wr = 1'b1;
            wdata   = ctrl_q | (DATA_W'(1) << HH_BIT);
         end
         S_PRD, S_SRD: begin
            rd_en = 1'b1;
            addr  = CMD_ADDR;
         end
         S_WR: begin
            wr_en = 1'b1;
            addr  = idx_q;
            wdata = reg_img[idx_q];
         end
         default: ;
      endcase
   end

   assign active   = (state_q != S_IDLE);
   assign done     = (state_q == S_DONE);
   assign err_code = err_q;

endmodule

// File: rtl/tfc_cmd_engine_chk.sv
module tfc_cmd_engine_chk #(
   parameter int DATA_W   = 8,
   parameter int REG_AW   = 3,
   parameter int BUSY_BIT = 7,
   parameter int HH_BIT   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_AW-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              wr_en,
   input logic              rd_en,
   input logic              ctrl_wr,
   input logic              active,
   input logic              done,
   input logic [2:0]        err_code
);

   localparam logic [REG_AW-1:0] CMD_ADDR = REG_AW'((1 << REG_AW) - 1);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!wr_en && !rd_en && !ctrl_wr && !done));

   p_no_addr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (addr != '0));

   p_write_after_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(rd_en, 2) && !$past(rdata[BUSY_BIT])));

   p_status_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (addr == CMD_ADDR));

   p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({wr_en, rd_en, ctrl_wr}) <= 1);

   p_high_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |-> wdata[HH_BIT]);

   p_poll_follows_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> rd_en);

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !active));

   p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> $stable(err_code));

endmodule

bind tfc_cmd_engine tfc_cmd_engine_chk #(
   .DATA_W   (DATA_W),
   .REG_AW   (REG_AW),
   .BUSY_BIT (BUSY_BIT),
   .HH_BIT   (HH_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .ctrl_wr  (ctrl_wr),
   .active   (active),
   .done     (done),
   .err_code (err_code)
);

// File: tb/tfc_cmd_engine_test.sv
module tfc_cmd_engine_test;

   localparam int TRIES = 60;
   localparam int WAITC = 400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  cmd_byte = '0;
   logic [47:0] param_bytes = '0;
   logic [3:0]  head_num = '0;
   logic [7:0]  ctrl_base = '0;
   logic        media_cmd = 1'b0;
   logic        irq_dev = 1'b0;
   logic        irq_inj = 1'b0;
   logic        irq;
   logic [7:0]  rdata = '0;
   logic [2:0]  addr;
   logic [7:0]  wdata;
   logic        wr_en, rd_en, ctrl_wr, active, done;
   logic [2:0]  err_code;

   assign irq = irq_dev | irq_inj;

   always #4 clk = ~clk;

   tfc_cmd_engine uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .cmd_byte    (cmd_byte),
      .param_bytes (param_bytes),
      .head_num    (head_num),
      .ctrl_base   (ctrl_base),
      .media_cmd   (media_cmd),
      .irq         (irq),
      .rdata       (rdata),
      .addr        (addr),
      .wdata       (wdata),
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .ctrl_wr     (ctrl_wr),
      .active      (active),
      .done        (done),
      .err_code    (err_code)
   );

   int nchk = 0;
   int nerr = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural device model
   int         busy_left = 0;
   int         busy_each = 0;
   int         stuck_after = -1;
   int         nwr = 0;
   int         irq_cnt = -1;
   int         irq_delay = -1;
   logic [7:0] flags = '0;

   always @(posedge clk) begin
      irq_dev <= 1'b0;
      if (irq_cnt == 0) begin
         irq_dev <= 1'b1;
         irq_cnt <= -1;
      end else if (irq_cnt > 0) begin
         irq_cnt <= irq_cnt - 1;
      end
      if (rd_en && addr == 3'd7) begin
         if (busy_left > 0) begin
            rdata     <= 8'h80 | flags;
            busy_left <= busy_left - 1;
         end else begin
            rdata <= flags;
         end
      end
      if (wr_en) begin
         nwr <= nwr + 1;
         if (addr == 3'd7) begin
            busy_left <= 0;
            irq_cnt   <= irq_delay;
         end else if (stuck_after >= 0 && nwr + 1 >= stuck_after) begin
            busy_left <= 1000000;
         end else begin
            busy_left <= busy_each;
         end
      end
   end

   // per-clock reference monitor
   logic [10:0] exp_q[$];
   logic [7:0]  exp_ctrl = '0;
   int          cyc = 0;
   int          cmd_cyc = 0;
   int          ctrl_cnt = 0;
   int          wr_seen = 0;
   int          rd_total = 0;
   bit          clear_seen = 1'b0;
   bit          rd_prev = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_prev) clear_seen = !rdata[7];
         if (wr_en) begin
            chk(clear_seen, "R3 write without clear status", 0, 1);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected write", int'({addr, wdata}), -1);
            end else begin
               logic [10:0] e;
               e = exp_q.pop_front();
               chk({addr, wdata} == e, "R2 write order/value", int'({addr, wdata}), int'(e));
            end
            clear_seen = 1'b0;
            wr_seen++;
            if (addr == 3'd7) cmd_cyc = cyc;
         end
         if (ctrl_wr) begin
            ctrl_cnt++;
            chk(wdata == exp_ctrl && wr_seen == 0, "R5 control write", int'(wdata), int'(exp_ctrl));
         end
         if (rd_en) rd_total++;
         rd_prev = rd_en && (addr == 3'd7);
      end
   end

   task automatic setup(input int bl, input int be, input int stk, input int idly, input logic [7:0] flg);
      busy_left   = bl;
      busy_each   = be;
      stuck_after = stk;
      irq_delay   = idly;
      flags       = flg;
      nwr         = 0;
      ctrl_cnt    = 0;
      wr_seen     = 0;
      rd_total    = 0;
      cmd_cyc     = 0;
      exp_q.delete();
   endtask

   task automatic expect_writes(input int upto);
      for (int k = 1; k <= upto; k++) begin
         if (k == 7) exp_q.push_back({3'd7, cmd_byte});
         else exp_q.push_back({3'(k), param_bytes[(k-1)*8 +: 8]});
      end
   endtask

   task automatic run(input logic [3:0] h, input bit med, input int inj_at,
                      output int err, output int done_at);
      int n;
      head_num  = h;
      media_cmd = med;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done && n < 5000) begin
         chk_active_once(n);
         irq_inj = (n == inj_at);
         @(negedge clk);
         n++;
      end
      irq_inj = 1'b0;
      err     = int'(err_code);
      done_at = cyc;
      chk(done == 1'b1, "R10 done reached", int'(done), 1);
      @(negedge clk);
      chk(!done && !active, "R10 done one cycle", int'({done, active}), 0);
   endtask

   task automatic chk_active_once(input int n);
      if (n == 0) chk(active == 1'b1, "R10 active after start", int'(active), 1);
   endtask

   initial begin
      #(8 * 150000);
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      int e, d;
      repeat (3) @(negedge clk);
      chk(!wr_en && !rd_en && !ctrl_wr && !active && !done && err_code == 3'd0,
          "R1 outputs in reset", int'({wr_en, rd_en, ctrl_wr, active, done}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!wr_en && !rd_en && !ctrl_wr && !active && !done && err_code == 3'd0,
          "R1 outputs after reset", int'({wr_en, rd_en, ctrl_wr, active, done}), 0);

      // normal command, low head
      cmd_byte    = 8'h20;
      param_bytes = 48'h66_55_44_33_22_11;
      ctrl_base   = 8'h02;
      setup(0, 0, -1, 10, 8'h00);
      expect_writes(7);
      run(4'd3, 1'b1, -1, e, d);
      chk(e == 0, "R9 clean status ok", e, 0);
      chk(exp_q.size() == 0, "R2 all writes issued", exp_q.size(), 0);
      chk(ctrl_cnt == 0, "R5 no control write for low head", ctrl_cnt, 0);
      chk(d - cmd_cyc == 16, "R8 completion timing", d - cmd_cyc, 16);
      repeat (5) @(negedge clk);
      chk(err_code == 3'd0 && !active, "R10 result held while idle", int'(err_code), 0);

      // high head
      cmd_byte    = 8'h70;
      param_bytes = 48'hA6_A5_A4_A3_A2_A1;
      exp_ctrl    = 8'h0A;
      setup(0, 0, -1, 3, 8'h00);
      expect_writes(7);
      run(4'd12, 1'b1, -1, e, d);
      chk(ctrl_cnt == 1, "R5 one control write for high head", ctrl_cnt, 1);
      chk(e == 0, "R5 high head result", e, 0);

      // device busy twice before every write
      setup(2, 2, -1, 4, 8'h00);
      expect_writes(7);
      run(4'd0, 1'b1, -1, e, d);
      chk(rd_total == 22, "R3 polls per write", rd_total, 22);
      chk(exp_q.size() == 0 && e == 0, "R3 busy device completes", e, 0);

      // busy forever from the start
      setup(1000000, 0, -1, 4, 8'h00);
      run(4'd1, 1'b1, -1, e, d);
      chk(e == 1, "R4 not ready code", e, 1);
      chk(rd_total == TRIES, "R4 poll count", rd_total, TRIES);
      chk(wr_seen == 0, "R4 no writes", wr_seen, 0);

      // locks up after the second write
      setup(0, 0, 2, 4, 8'h00);
      expect_writes(2);
      run(4'd1, 1'b1, -1, e, d);
      chk(e == 1, "R4 not ready mid sequence", e, 1);
      chk(wr_seen == 2, "R4 writes stop", wr_seen, 2);

      // no completion interrupt
      setup(0, 0, -1, -1, 8'h00);
      expect_writes(7);
      run(4'd2, 1'b1, -1, e, d);
      chk(e == 2, "R7 timeout code", e, 2);
      chk(d - cmd_cyc == WAITC + 1, "R7 timeout timing", d - cmd_cyc, WAITC + 1);

      // stray interrupt during the write phase
      setup(0, 3, -1, -1, 8'h00);
      expect_writes(7);
      run(4'd2, 1'b1, 4, e, d);
      chk(e == 3, "R7 missed interrupt code", e, 3);
      chk(d - cmd_cyc == WAITC + 1, "R7 missed timing", d - cmd_cyc, WAITC + 1);

      // stale interrupt while idle, then no completion
      irq_inj = 1'b1;
      @(negedge clk);
      irq_inj = 1'b0;
      repeat (3) @(negedge clk);
      setup(0, 0, -1, -1, 8'h00);
      expect_writes(7);
      run(4'd2, 1'b1, -1, e, d);
      chk(e == 2, "R6 stale irq flushed (timeout)", e, 2);

      // stale interrupt while idle, then delayed completion
      irq_inj = 1'b1;
      @(negedge clk);
      irq_inj = 1'b0;
      repeat (3) @(negedge clk);
      setup(0, 0, -1, 10, 8'h00);
      expect_writes(7);
      run(4'd2, 1'b1, -1, e, d);
      chk(e == 0, "R6 stale irq flushed (ok)", e, 0);
      chk(d - cmd_cyc == 16, "R6 wait not cut short", d - cmd_cyc, 16);

      // status classification
      setup(0, 0, -1, 2, 8'h01);
      expect_writes(7);
      run(4'd0, 1'b1, -1, e, d);
      chk(e == 4, "R8 error bit", e, 4);

      setup(0, 0, -1, 2, 8'h21);
      expect_writes(7);
      run(4'd0, 1'b1, -1, e, d);
      chk(e == 4, "R8 error beats write fault", e, 4);

      setup(0, 0, -1, 2, 8'h20);
      expect_writes(7);
      run(4'd0, 1'b1, -1, e, d);
      chk(e == 5, "R9 write fault on media command", e, 5);

      setup(0, 0, -1, 2, 8'h20);
      expect_writes(7);
      run(4'd0, 1'b0, -1, e, d);
      chk(e == 0, "R9 write fault ignored for other command", e, 0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule